// File: doc/BRIEF.md
# Three-Channel Quantum-Stepped PWM Generator

This block produces several independent pulse-width-modulated outputs from one fixed reference clock. Each channel divides the reference clock by a programmable amount (32 minus a 4-bit code, so 17 to 32 reference cycles) to form a time quantum. A period always lasts 1024 quanta. With a 9.6 MHz reference clock the output rate runs from roughly 293 Hz up to roughly 551 Hz.

A 10-bit duty code D sets the high time to D+1 quanta, counted from the start of each period. The high time can therefore be anything from one quantum up to the whole period, and D=1023 holds the output high. An output of zero width is only reached by disabling the channel, which forces it low. Software programs the channels over a small synchronous byte bus. Each channel has a pair of byte registers, and one shared register holds an enable bit per channel. Values written while a channel runs are taken up only at the next period boundary, so a period is never cut short or glitched.

Top module: `pwm_bank_top`

## Requirements
- R1: After reset every register reads 0x00 and every bit of `pwm_out` is low.
- R2: Channel i owns byte address 2i, which holds D[7:0], and byte address 2i+1, which holds D[9:8] in bits [1:0] and the frequency code F in bits [7:4]. Address 6 holds the enable bit of channel i at bit i. Every register reads back the last value written to its implemented bits.
- R3: Bits [3:2] of each high byte, and bits [7:3] of the enable register, read as zero. Address 7 reads as zero, and a write to it changes no register.
- R4: One quantum lasts 32−F reference clock cycles, and one period lasts exactly 1024 quanta: 1024·(32−F) cycles.
- R5: Within each period the output is high for (D+1) quanta, starting at the period start, and low for the rest of the period.
- R6: With D=1023 the enabled output stays high and never falls.
- R7: While a channel's enable bit is 0 its output is low. Clearing the bit drives the output low on the second clock edge after the write edge.
- R8: Setting an enable bit from 0 to 1 restarts that channel's divider and quantum count. The output goes high on the second clock edge after the write edge, and a full (D+1)-quantum high time follows.
- R9: D and F written while a channel runs leave the current period unchanged and apply from the next period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | AW (3) | Byte address for writes and reads |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pwm_out | output | NCH (3) | One PWM output per channel |

## Verification
A corrupted divider or quantum count shows up as a wrong high time or a wrong period length. It is measured edge to edge within the first full period after enable, so the error appears within about 33k cycles. A working copy of D or F that is taken up at the wrong moment shows up in the period that straddles a mid-period write, so that period is measured on its own. A broken enable or restart path is visible at the outputs within two cycles of the write. Register decode faults are visible at once on the combinational read data.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int BUS_W     = 8;
    localparam int DUTY_W    = 10;
    localparam int FREQ_W    = 4;
    localparam int DIV_BASE  = 32;
    localparam int PRE_W     = $clog2(DIV_BASE);
    localparam int LO_W      = 8;
    localparam int HI_DUTY_W = DUTY_W - LO_W;
    localparam int FREQ_LSB  = 4;

    typedef struct packed {
        logic [FREQ_W-1:0] freq;
        logic [DUTY_W-1:0] duty;
    } ch_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         addr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    output ch_cfg_t [NCH-1:0]     cfg,
    output logic [NCH-1:0]        en
);
    localparam int EN_ADDR = 2 * NCH;

    typedef struct packed {
        ch_cfg_t [NCH-1:0] cfg;
        logic [NCH-1:0]    en;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (int'(addr) == 2 * i) begin
                    r_d.cfg[i].duty[LO_W-1:0] = wdata;
                end
                if (int'(addr) == 2 * i + 1) begin
                    r_d.cfg[i].duty[DUTY_W-1:LO_W] = wdata[HI_DUTY_W-1:0];
                    r_d.cfg[i].freq = wdata[FREQ_LSB +: FREQ_W];
                end
            end
            if (int'(addr) == EN_ADDR) begin
                r_d.en = wdata[NCH-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(addr) == 2 * i) begin
                rdata = r_q.cfg[i].duty[LO_W-1:0];
            end
            if (int'(addr) == 2 * i + 1) begin
                rdata[HI_DUTY_W-1:0]       = r_q.cfg[i].duty[DUTY_W-1:LO_W];
                rdata[FREQ_LSB +: FREQ_W]  = r_q.cfg[i].freq;
            end
        end
        if (int'(addr) == EN_ADDR) begin
            rdata[NCH-1:0] = r_q.en;
        end
    end

    assign cfg = r_q.cfg;
    assign en  = r_q.en;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  ch_cfg_t cfg_in,
    output logic    pwm_o
);
    typedef struct packed {
        logic              run;
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] qcnt;
        ch_cfg_t           act;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic [PRE_W-1:0] last_pre;

    assign last_pre = PRE_W'(DIV_BASE - 1) - PRE_W'(s_q.act.freq);

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d = '0;
        end else if (!s_q.run) begin
            s_d.run  = 1'b1;
            s_d.pre  = '0;
            s_d.qcnt = '0;
            s_d.act  = cfg_in;
        end else if (s_q.pre == last_pre) begin
            s_d.pre = '0;
            if (s_q.qcnt == '1) begin
                s_d.qcnt = '0;
                s_d.act  = cfg_in;
            end else begin
                s_d.qcnt = s_q.qcnt + 1'b1;
            end
        end else begin
            s_d.pre = s_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pwm_o = s_q.run && (s_q.qcnt <= s_q.act.duty);
endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
    import pwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    ch_cfg_t [NCH-1:0] cfg_vec;
    logic [NCH-1:0]    en_vec;

    pwm_regs #(.NCH(NCH), .AW(AW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .cfg   (cfg_vec),
        .en    (en_vec)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        pwm_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (en_vec[g]),
            .cfg_in (cfg_vec[g]),
            .pwm_o  (pwm_out[g])
        );
    end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
    import pwm_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [AW-1:0]     addr,
    input logic [BUS_W-1:0]  wdata,
    input logic [BUS_W-1:0]  rdata,
    input logic [NCH-1:0]    en_vec,
    input logic [NCH-1:0]    pwm_out
);
    localparam int EN_ADDR = 2 * NCH;

    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[0] && int'(addr) < EN_ADDR) |-> rdata[FREQ_LSB-1:HI_DUTY_W] == '0);

    assert_en_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(addr) == EN_ADDR) |-> (rdata >> NCH) == '0);

    assert_en_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && int'($past(addr)) == EN_ADDR && int'(addr) == EN_ADDR)
        |-> rdata[NCH-1:0] == $past(wdata[NCH-1:0]));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_start_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en_vec[g]) |=> pwm_out[g]);

        assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en_vec[g]) |=> !pwm_out[g]);

        assert_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!en_vec[g] && !$past(en_vec[g])) |-> !pwm_out[g]);
    end
endmodule

bind pwm_bank_top pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .en_vec  (en_vec),
    .pwm_out (pwm_out)
);

// File: tb/sim_pwm_bank_top.sv
module sim_pwm_bank_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 3;
    localparam int AW  = 3;

    logic clk = 0;
    logic rst_n = 0;
    logic bus_wr = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [NCH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    pwm_bank_top #(.NCH(NCH), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard state
    int    exp_hi  [NCH][$];
    int    exp_per [NCH][$];
    string exp_tag [NCH][$];
    bit    prev_lvl  [NCH];
    bit    have_rise [NCH];
    int    rise_t [NCH];
    int    fall_t [NCH];
    int    falls  [NCH];

    task automatic check_eq(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (pwm_out[c] && !prev_lvl[c]) begin
                    if (have_rise[c]) begin
                        if (exp_hi[c].size() > 0) begin
                            string t;
                            int eh;
                            int ep;
                            t  = exp_tag[c].pop_front();
                            eh = exp_hi[c].pop_front();
                            ep = exp_per[c].pop_front();
                            check_eq($sformatf("R5/%s", t), $sformatf("ch%0d high", c),
                                     fall_t[c] - rise_t[c], eh);
                            check_eq($sformatf("R4/%s", t), $sformatf("ch%0d period", c),
                                     cyc - rise_t[c], ep);
                        end else begin
                            check_eq("R4", $sformatf("ch%0d unexpected period", c), 1, 0);
                        end
                    end
                    rise_t[c]    = cyc;
                    have_rise[c] = 1;
                end
                if (!pwm_out[c] && prev_lvl[c]) begin
                    fall_t[c] = cyc;
                    falls[c]++;
                end
                prev_lvl[c] = pwm_out[c];
            end
        end
    end

    task automatic mon_clear();
        @(posedge clk);
        #1;
        for (int c = 0; c < NCH; c++) begin
            have_rise[c] = 0;
            falls[c] = 0;
            exp_hi[c].delete();
            exp_per[c].delete();
            exp_tag[c].delete();
        end
    endtask

    task automatic expect_period(int c, int d, int f, string tag);
        exp_hi[c].push_back((d + 1) * (32 - f));
        exp_per[c].push_back(1024 * (32 - f));
        exp_tag[c].push_back(tag);
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        bus_wr = 1;
        bus_addr = AW'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(int a, output int d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic set_chan(int c, int d, int f);
        bus_write(2 * c, d & 8'hFF);
        bus_write(2 * c + 1, ((d >> 8) & 3) | (f << 4));
    endtask

    task automatic queues_empty(string req);
        for (int c = 0; c < NCH; c++)
            check_eq(req, $sformatf("ch%0d periods left unmeasured", c), exp_hi[c].size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        int hc;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset state
        for (int a = 0; a < 7; a++) begin
            bus_read(a, v);
            check_eq("R1", $sformatf("reg %0d after reset", a), v, 0);
        end
        check_eq("R1", "outputs after reset", int'(pwm_out), 0);

        // R2: read-back of implemented bits
        bus_write(0, 8'hA5); bus_write(1, 8'h92);
        bus_write(2, 8'h5A); bus_write(3, 8'h61);
        bus_write(4, 8'h3C); bus_write(5, 8'hF0);
        bus_read(0, v); check_eq("R2", "ch0 low byte", v, 8'hA5);
        bus_read(1, v); check_eq("R2", "ch0 high byte", v, 8'h92);
        bus_read(2, v); check_eq("R2", "ch1 low byte", v, 8'h5A);
        bus_read(3, v); check_eq("R2", "ch1 high byte", v, 8'h61);
        bus_read(4, v); check_eq("R2", "ch2 low byte", v, 8'h3C);
        bus_read(5, v); check_eq("R2", "ch2 high byte", v, 8'hF0);
        check_eq("R7", "outputs low while disabled", int'(pwm_out), 0);

        // R3: reserved bits and unused address
        bus_write(1, 8'hFF);
        bus_read(1, v); check_eq("R3", "reserved high bits", v, 8'hF3);
        bus_write(6, 8'hF8);
        bus_read(6, v); check_eq("R3", "enable upper bits", v, 0);
        bus_write(7, 8'h55);
        bus_read(7, v); check_eq("R3", "address 7 read", v, 0);
        bus_read(0, v); check_eq("R3", "addr 7 write left ch0 low", v, 8'hA5);
        bus_read(1, v); check_eq("R3", "addr 7 write left ch0 high", v, 8'hF3);
        bus_read(6, v); check_eq("R3", "addr 7 write left enable", v, 0);
        repeat (2) @(negedge clk);
        check_eq("R7", "outputs low, enable clear", int'(pwm_out), 0);

        // Phase A: shortest high, constant high, mid duty
        set_chan(0, 0, 15);
        set_chan(1, 1023, 0);
        set_chan(2, 511, 8);
        mon_clear();
        expect_period(0, 0, 15, "min duty");
        expect_period(2, 511, 8, "half duty");
        bus_write(6, 8'h07);
        repeat (26000) @(negedge clk);
        queues_empty("R4");
        check_eq("R6", "ch1 falls at D=1023", falls[1], 0);
        check_eq("R6", "ch1 level at D=1023", int'(pwm_out[1]), 1);
        bus_write(6, 8'h00);
        @(negedge clk);
        check_eq("R7", "outputs after disable", int'(pwm_out), 0);

        // Phase B: restart high, near-full duty, deferred update
        set_chan(0, 3, 15);
        set_chan(1, 1022, 15);
        mon_clear();
        expect_period(0, 3, 15, "R9 old values kept");
        expect_period(0, 7, 14, "R9 new values at boundary");
        expect_period(1, 1022, 15, "near full");
        expect_period(1, 1022, 15, "near full");
        bus_write(6, 8'h03);
        @(negedge clk);
        check_eq("R8", "ch0 high after enable", int'(pwm_out[0]), 1);
        check_eq("R8", "ch1 high after enable", int'(pwm_out[1]), 1);
        repeat (200) @(negedge clk);
        set_chan(0, 7, 14);
        repeat (36000) @(negedge clk);
        queues_empty("R9");

        // Phase C: restart mid-period gives a full high time
        mon_clear();
        bus_write(6, 8'h02);
        bus_write(6, 8'h03);
        @(negedge clk);
        check_eq("R8", "ch0 high after re-enable", int'(pwm_out[0]), 1);
        hc = 0;
        while (pwm_out[0] && hc < 2000) begin
            hc++;
            @(negedge clk);
        end
        check_eq("R8", "ch0 high time after restart", hc, 8 * 18);

        bus_write(6, 8'h00);
        @(negedge clk);
        check_eq("R7", "outputs after final disable", int'(pwm_out), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule